// File: doc/BRIEF.md
# MAC Event Interrupt Collector

This block gathers seven single-cycle event strobes from a network MAC into one level interrupt line. Each strobe sets its own sticky bit in a pending register. The bit stays set until software clears it by writing a 1 to it. An enable register picks which pending bits are allowed to reach the interrupt line. A pending bit is recorded even while its enable is off. When software then turns that enable on, the line rises on the next cycle, and no event that arrived while it was disabled is lost.

Software reaches both registers through a plain single-cycle register port. Writes are strobed, reads are combinational, and the word offset selects the register. The enable register is a full-word register: software reads it, changes the bits it wants and writes it back. The interrupt output is registered, which keeps its timing independent of the depth of the OR tree.

Top module: `mac_irq_collector`

## Requirements
- R1: Event input `evt_i[k]` sets pending bit k. The bit layout is: bit0 transmit frame done, bit1 transmit error, bit2 receive frame done, bit3 receive error, bit4 receive busy/dropped, bit5 transmit control frame, bit6 receive control frame. The pending register reads back at offset 0x04 with this layout.
- R2: A pending bit is set by its event whatever the value of its enable bit, and it stays set when the event strobe goes away.
- R3: A write to offset 0x04 clears each pending bit whose write-data bit is 1 and leaves the bits whose write-data bit is 0 unchanged.
- R4: When an event and a write-1-to-clear hit the same pending bit in the same cycle, the bit ends up set.
- R5: The enable register at offset 0x08 uses the pending bit layout. A write replaces all seven enables and a read returns them. A write to the enable register does not change the pending register.
- R6: `irq_o` equals the OR over all bits of (pending AND enable), registered, so it reflects register state one clock after that state changes.
- R7: Enabling a bit that is already pending raises `irq_o` one cycle after the enable write. Disabling it, or clearing it, lowers `irq_o` one cycle later.
- R8: Reset, which is synchronous and active low, clears the pending register, the enable register and `irq_o`. Read bits 31..7 are always zero. Offsets other than 0x04 and 0x08 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 7 | Event strobes, bit layout as in R1 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
The bench builds the block with its default parameters: seven events, an 8-bit offset and a 32-bit data word. With these values, the unused upper data bits, the unmapped offset 0x0C and the two real offsets are all reachable directly from the port. A vector table pairs event patterns with enable patterns, including disjoint and fully overlapping ones, and checks the readback and the line level for each pair. Directed tests then cover the one-cycle line latency, enabling an already pending bit, a partial clear, and an event that collides with a clear of the same bit.

// File: rtl/mac_irq_pkg.sv
// Package: shared constants for the MAC event interrupt collector.
// Assumes the event bit order below is fixed; software decodes it.
package mac_irq_pkg;
    localparam int NUM_EV = 7;

    typedef enum int {
        EV_TX_DONE  = 0,
        EV_TX_ERR   = 1,
        EV_RX_DONE  = 2,
        EV_RX_ERR   = 3,
        EV_RX_BUSY  = 4,
        EV_TX_CTRL  = 5,
        EV_RX_CTRL  = 6
    } ev_idx_e;

    localparam logic [7:0] OFS_PEND = 8'h04;
    localparam logic [7:0] OFS_ENAB = 8'h08;
endpackage

// File: rtl/mac_irq_pend_bank.sv
// Sticky pending bits, one per event.
// Assumes clr_i is already qualified by a write to the pending offset.
// A set in the same cycle as a clear wins, so no event is dropped.
module mac_irq_pend_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar k = 0; k < N; k++) begin : g_bit
        // Per-bit sticky latch with set priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_o[k] <= 1'b0;
            else if (set_i[k])
                q_o[k] <= 1'b1;
            else if (clr_i[k])
                q_o[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/mac_irq_enab_reg.sv
// Plain enable register. A write replaces every bit.
// Assumes we_i is already qualified by a write to the enable offset.
module mac_irq_enab_reg #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    // Hold the enables, load the full word on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (we_i)
            q_o <= d_i;
    end
endmodule

// File: rtl/mac_irq_line.sv
// Registered interrupt line: OR of pending AND enable.
// Assumes both inputs come from registers, so the line lags them by one clock.
module mac_irq_line #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] enab_i,
    output logic         irq_o
);
    logic [N-1:0] live;

    // Gate each pending bit with its enable.
    always_comb live = pend_i & enab_i;

    // Register the reduced request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= |live;
    end
endmodule

// File: rtl/mac_irq_collector.sv
// Top: decodes the register port, holds the pending and enable registers
// and drives the registered interrupt line.
// Assumes one register access per cycle, with combinational read data.
module mac_irq_collector #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int N      = mac_irq_pkg::NUM_EV
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      evt_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(mac_irq_pkg::OFS_PEND);
    localparam logic [ADDR_W-1:0] A_ENAB = ADDR_W'(mac_irq_pkg::OFS_ENAB);

    logic         hit_pend, hit_enab;
    logic [N-1:0] clr_vec;
    logic [N-1:0] src_q;
    logic [N-1:0] mask_q;
    logic         unused_wdata;

    // Decode which register the current access selects.
    always_comb begin
        hit_pend = (reg_addr_i == A_PEND);
        hit_enab = (reg_addr_i == A_ENAB);
    end

    // Clear vector from a write to the pending offset.
    always_comb clr_vec = (reg_wr_i && hit_pend) ? reg_wdata_i[N-1:0] : '0;

    assign unused_wdata = ^reg_wdata_i[DATA_W-1:N];

    mac_irq_pend_bank #(.N(N)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_i),
        .clr_i (clr_vec),
        .q_o   (src_q)
    );

    mac_irq_enab_reg #(.N(N)) u_enab (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (reg_wr_i && hit_enab),
        .d_i   (reg_wdata_i[N-1:0]),
        .q_o   (mask_q)
    );

    mac_irq_line #(.N(N)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (src_q),
        .enab_i (mask_q),
        .irq_o  (irq_o)
    );

    // Read mux: zero-extended register or zero for unmapped offsets.
    always_comb begin
        reg_rdata_o = '0;
        if (hit_pend)
            reg_rdata_o[N-1:0] = src_q;
        else if (hit_enab)
            reg_rdata_o[N-1:0] = mask_q;
    end
endmodule

// File: rtl/mac_irq_collector_chk.sv
// Checker for mac_irq_collector, attached by bind below.
// Assumes the default offsets from mac_irq_pkg.
module mac_irq_collector_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int N      = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      evt_i,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic [DATA_W-1:0] reg_rdata_o,
    input logic              irq_o,
    input logic [N-1:0]      src_q,
    input logic [N-1:0]      mask_q
);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(mac_irq_pkg::OFS_PEND);
    localparam logic [ADDR_W-1:0] A_ENAB = ADDR_W'(mac_irq_pkg::OFS_ENAB);

    // R1 R2 R4: every strobed event is pending on the next cycle, clear or not.
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((src_q & $past(evt_i)) == $past(evt_i)));

    // R3: a 1 written to the pending offset without a colliding event clears the bit.
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == A_PEND && ((reg_wdata_i[N-1:0] & ~evt_i) != '0))
        |=> ((src_q & $past(reg_wdata_i[N-1:0] & ~evt_i)) == '0));

    // R5: enables hold unless the enable offset is written.
    a_r5_enab_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_addr_i == A_ENAB) |=> $stable(mask_q));

    // R6 R7: the line follows the gated pending state one cycle later.
    a_r6_line_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == (|($past(src_q) & $past(mask_q)))));

    // R8: upper read bits are always zero.
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[DATA_W-1:N] == '0);
endmodule

bind mac_irq_collector mac_irq_collector_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(N)
) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
    .src_q(src_q), .mask_q(mask_q)
);

// File: tb/mac_irq_collector_tb.sv
module mac_irq_collector_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt = '0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          total = 0;
    int          bad = 0;

    always #4 clk = ~clk;

    mac_irq_collector u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    // {event, enable, expected pending, expected line}
    localparam logic [21:0] VEC [9] = '{
        {7'h01, 7'h01, 7'h01, 1'b1},
        {7'h02, 7'h00, 7'h02, 1'b0},
        {7'h04, 7'h7B, 7'h04, 1'b0},
        {7'h08, 7'h08, 7'h08, 1'b1},
        {7'h10, 7'h6F, 7'h10, 1'b0},
        {7'h20, 7'h20, 7'h20, 1'b1},
        {7'h40, 7'h3F, 7'h40, 1'b0},
        {7'h55, 7'h2A, 7'h55, 1'b0},
        {7'h7F, 7'h40, 7'h7F, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rreg(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input logic [6:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        rreg(8'h04, rv); chk("R8 reset pending", rv, 32'h0);
        rreg(8'h08, rv); chk("R8 reset enable", rv, 32'h0);
        chk("R8 reset irq", {31'h0, irq}, 32'h0);

        // R1 R2 R6 vector walk
        for (int i = 0; i < 9; i++) begin
            wreg(8'h04, 32'h7F);
            wreg(8'h08, {25'h0, VEC[i][14:8]});
            @(negedge clk);
            pulse(VEC[i][21:15]);
            @(negedge clk);
            rreg(8'h04, rv); chk("R1 R2 pending from event", rv, {25'h0, VEC[i][7:1]});
            chk("R6 line level", {31'h0, irq}, {31'h0, VEC[i][0]});
        end

        // R5 enable readback, R8 upper bits zero, R5 enable write leaves pending alone
        wreg(8'h04, 32'h7F);
        pulse(7'h11);
        wreg(8'h08, 32'hFFFF_FFAA);
        rreg(8'h08, rv); chk("R5 R8 enable readback", rv, 32'h2A);
        rreg(8'h04, rv); chk("R5 pending untouched by enable write", rv, 32'h11);

        // R8 unmapped offset
        wreg(8'h0C, 32'h7F);
        rreg(8'h0C, rv); chk("R8 unmapped reads zero", rv, 32'h0);
        rreg(8'h04, rv); chk("R8 unmapped write pending", rv, 32'h11);
        rreg(8'h08, rv); chk("R8 unmapped write enable", rv, 32'h2A);

        // R3 partial clear and zero write
        wreg(8'h08, 32'h0);
        pulse(7'h0F);
        wreg(8'h04, 32'h05);
        rreg(8'h04, rv); chk("R3 partial clear", rv, 32'h1A);
        wreg(8'h04, 32'h00);
        rreg(8'h04, rv); chk("R3 zero write no effect", rv, 32'h1A);

        // R7 enabling an already pending bit
        @(negedge clk);
        chk("R7 masked pending no irq", {31'h0, irq}, 32'h0);
        wreg(8'h08, 32'h02);
        chk("R7 irq not yet on write cycle", {31'h0, irq}, 32'h0);
        @(negedge clk);
        chk("R7 irq after unmask", {31'h0, irq}, 32'h1);
        wreg(8'h08, 32'h00);
        @(negedge clk);
        chk("R7 irq drops after mask", {31'h0, irq}, 32'h0);

        // R4 event collides with clear of the same bit
        wreg(8'h04, 32'h7F);
        @(negedge clk);
        pulse(7'h08);
        @(negedge clk);
        wr = 1'b1; addr = 8'h04; wdata = 32'h0A; evt = 7'h02;
        @(negedge clk);
        wr = 1'b0; wdata = '0; evt = '0;
        rreg(8'h04, rv); chk("R4 event beats clear", rv, 32'h02);

        // R6 latency from event to line, then clear drops it
        wreg(8'h04, 32'h7F);
        wreg(8'h08, 32'h7F);
        @(negedge clk);
        pulse(7'h01);
        chk("R6 irq low one cycle after event", {31'h0, irq}, 32'h0);
        @(negedge clk);
        chk("R6 irq high two cycles after event", {31'h0, irq}, 32'h1);
        wreg(8'h04, 32'h01);
        @(negedge clk);
        chk("R7 irq drops after clear", {31'h0, irq}, 32'h0);

        // R8 reset in mid-run
        pulse(7'h7F);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rreg(8'h04, rv); chk("R8 reset clears pending", rv, 32'h0);
        rreg(8'h08, rv); chk("R8 reset clears enable", rv, 32'h0);
        chk("R8 reset clears irq", {31'h0, irq}, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule